// File: doc/BRIEF.md
# Protection-Filtered AXI4-Lite Register File

This block is an AXI4-Lite slave that holds a handful of 32-bit control words and one 64-bit value. Every field carries a six-flag permission mask. The mask is compared with the protection bits that come with each transaction: the privilege level, the secure or nonsecure state, and whether the access is for data or for instructions. A field that the master may not touch behaves as if it were not there. Writes leave it unchanged, and reads return zero in its bit positions. A register with no field the master may reach answers with a decode error.

The 64-bit value is read as two words. Reading the low word captures the upper half into a holding register and opens a two-word read. While that read is open, an access to either half of the 64-bit value from a master with lower privilege is refused with a slave error and zero data. This stops a less trusted agent from breaking into the open read or seeing what it holds. When the high word has been read, the holding register is wiped. A parameter removes both the interruption guard and the wipe.

Top module: `prot_regfile`

## Requirements
- R1: The protection bits decode as follows: bit 0 set means privileged and clear means user; bit 1 set means nonsecure and clear means secure; bit 2 set means instruction and clear means data. A field is reachable only when its flags allow all three decoded attributes.
- R2: When a register has at least one reachable field, the response is OKAY (00). Bits of refused fields read as zero, and writes do not change them.
- R3: When no field of the addressed register is reachable, the response is DECERR (11). Read data is zero and a write changes nothing.
- R4: Map, at word-aligned byte offsets. 0x00 holds field A in bits 15:0, open to all, and field B in bits 31:16, denied to user accesses. 0x04 holds a 32-bit key that only secure data accesses may reach. 0x08 and 0x0C are the low and high halves of the 64-bit value, denied to instruction accesses. Any other address, including a misaligned one, has no fields. All storage resets to zero.
- R5: An OKAY read of 0x08 returns the current low half, copies the current high half into the holding register, and opens a two-word read that records the reader's protection bits.
- R6: An OKAY read of 0x0C returns the holding register under the reader's field mask and closes the open two-word read.
- R7: While a two-word read is open, a read or write of 0x08 or 0x0C is answered SLVERR (10) with zero read data and no side effect if it is less privileged. It is less privileged if the recorded access was privileged and the new one is user, or if the recorded access was secure and the new one is nonsecure.
- R8: Accesses at the same or higher privilege proceed while a two-word read is open. A new OKAY read of 0x08 replaces the recorded protection bits.
- R9: When an OKAY read of 0x0C completes, the holding register becomes zero, so a later read of 0x0C with no read open returns zero.
- R10: With GUARD_EN = 0, neither R7 nor R9 applies: interrupting accesses proceed normally and the holding register keeps its value.
- R11: AW and W are accepted in either order. B is issued only after both have arrived, and BVALID and RVALID with their payloads stay steady until accepted.
- R12: Write strobe bit i enables byte lane i (bits 8i+7:8i). Disabled lanes keep their value.
- R13: After reset, BVALID and RVALID are low, AWREADY, WREADY and ARREADY are high, and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| aw_addr | input | ADDR_W | Write byte address |
| aw_prot | input | 3 | Write protection bits |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data ready |
| w_data | input | 32 | Write data |
| w_strb | input | 4 | Write byte strobes |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_resp | output | 2 | Write response code |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address ready |
| ar_addr | input | ADDR_W | Read byte address |
| ar_prot | input | 3 | Read protection bits |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_data | output | 32 | Read data |
| r_resp | output | 2 | Read response code |

## Verification
A read result is registered on the clock edge that accepts AR, so RVALID and its data are present from the falling edge that follows the handshake. A write commits on the edge after the later of its AW and W handshakes, so BVALID is checked at the second falling edge after the last address or data handshake. The bench raises BREADY or RREADY only just after a rising edge. It compares each response at the falling edge where valid and ready are both high, before the accepting edge, so no comparison races the handshake. A second instance with the guard disabled sees the same stimulus, and each scoreboard entry carries the expected result for both instances.

// File: rtl/prot_regfile_pkg.sv
package prot_regfile_pkg;

    localparam int DATA_W     = 32;
    localparam int STRB_W     = DATA_W / 8;
    localparam int NUM_WORDS  = 4;
    localparam int WIDX_W     = $clog2(NUM_WORDS);
    localparam int NUM_FIELDS = 5;
    localparam logic [WIDX_W-1:0] WIDE_LO = 2'd2;
    localparam logic [WIDX_W-1:0] WIDE_HI = 2'd3;

    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_EXOKAY = 2'b01,
        RESP_SLVERR = 2'b10,
        RESP_DECERR = 2'b11
    } resp_e;

    // attribute flags carried by one field
    typedef struct packed {
        logic user;
        logic priv;
        logic secure;
        logic nonsecure;
        logic data;
        logic instr;
    } perm_t;

    // decoded protection bits, MSB first: bit 2, bit 1, bit 0
    typedef struct packed {
        logic is_instr;
        logic is_nonsec;
        logic is_priv;
    } prot_t;

    typedef struct packed {
        logic [WIDX_W-1:0] word;
        logic [5:0]        lsb;
        logic [6:0]        width;
        perm_t             perm;
    } field_t;

    localparam field_t FIELD_MAP [NUM_FIELDS] = '{
        '{word: 2'd0, lsb: 6'd0,  width: 7'd16, perm: 6'b111111},
        '{word: 2'd0, lsb: 6'd16, width: 7'd16, perm: 6'b011111},
        '{word: 2'd1, lsb: 6'd0,  width: 7'd32, perm: 6'b111010},
        '{word: 2'd2, lsb: 6'd0,  width: 7'd32, perm: 6'b111110},
        '{word: 2'd3, lsb: 6'd0,  width: 7'd32, perm: 6'b111110}
    };

    function automatic logic field_ok(input perm_t p, input prot_t t);
        logic lvl, sec, kind;
        lvl  = t.is_priv   ? p.priv      : p.user;
        sec  = t.is_nonsec ? p.nonsecure : p.secure;
        kind = t.is_instr  ? p.instr     : p.data;
        return lvl && sec && kind;
    endfunction

    function automatic logic less_priv(input prot_t held, input prot_t req);
        return (held.is_priv && !req.is_priv) || (!held.is_nonsec && req.is_nonsec);
    endfunction

    function automatic logic [DATA_W-1:0] access_mask(input logic [WIDX_W-1:0] w,
                                                      input prot_t t);
        logic [DATA_W-1:0] m;
        logic [DATA_W:0]   f;
        m = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            f = ((DATA_W+1)'(1) << FIELD_MAP[i].width) - (DATA_W+1)'(1);
            f = f << FIELD_MAP[i].lsb;
            if (FIELD_MAP[i].word == w && field_ok(FIELD_MAP[i].perm, t))
                m = m | f[DATA_W-1:0];
        end
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input logic [STRB_W-1:0] s);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < STRB_W; i++)
            m[i*8 +: 8] = {8{s[i]}};
        return m;
    endfunction

endpackage

// File: rtl/prot_regfile_core.sv
module prot_regfile_core
    import prot_regfile_pkg::*;
#(
    parameter bit GUARD_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [WIDX_W-1:0] wr_word,
    input  logic              wr_mapped,
    input  prot_t             wr_prot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [STRB_W-1:0] wr_strb,
    output resp_e             wr_resp,
    input  logic              rd_req,
    input  logic [WIDX_W-1:0] rd_word,
    input  logic              rd_mapped,
    input  prot_t             rd_prot,
    output logic [DATA_W-1:0] rd_data,
    output resp_e             rd_resp
);

    logic [NUM_WORDS-1:0][DATA_W-1:0] store_q;
    logic [DATA_W-1:0]                hold_q;
    logic                             busy_q;
    prot_t                            busy_prot_q;

    logic [DATA_W-1:0] wr_amask, wr_bmask, rd_amask, rd_src;
    logic              wr_wide, wr_block, wr_apply;
    logic              rd_wide, rd_block, rd_ok;

    // write side
    always_comb begin
        wr_amask = wr_mapped ? access_mask(wr_word, wr_prot) : '0;
        wr_bmask = wr_amask & lane_mask(wr_strb);
        wr_wide  = (wr_word == WIDE_LO) || (wr_word == WIDE_HI);
        wr_block = GUARD_EN && busy_q && wr_wide && less_priv(busy_prot_q, wr_prot);
        if (wr_amask == '0)
            wr_resp = RESP_DECERR;
        else if (wr_block)
            wr_resp = RESP_SLVERR;
        else
            wr_resp = RESP_OKAY;
        wr_apply = wr_req && (wr_resp == RESP_OKAY);
    end

    // read side
    always_comb begin
        rd_amask = rd_mapped ? access_mask(rd_word, rd_prot) : '0;
        rd_wide  = (rd_word == WIDE_LO) || (rd_word == WIDE_HI);
        rd_block = GUARD_EN && busy_q && rd_wide && less_priv(busy_prot_q, rd_prot);
        rd_src   = (rd_word == WIDE_HI) ? hold_q : store_q[rd_word];
        if (rd_amask == '0) begin
            rd_resp = RESP_DECERR;
            rd_data = '0;
        end else if (rd_block) begin
            rd_resp = RESP_SLVERR;
            rd_data = '0;
        end else begin
            rd_resp = RESP_OKAY;
            rd_data = rd_src & rd_amask;
        end
        rd_ok = rd_req && (rd_resp == RESP_OKAY);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q     <= '0;
            hold_q      <= '0;
            busy_q      <= 1'b0;
            busy_prot_q <= '0;
        end else begin
            if (wr_apply)
                store_q[wr_word] <= (store_q[wr_word] & ~wr_bmask) | (wr_data & wr_bmask);
            if (rd_ok && rd_word == WIDE_LO) begin
                hold_q      <= store_q[WIDE_HI];
                busy_q      <= 1'b1;
                busy_prot_q <= rd_prot;
            end else if (rd_ok && rd_word == WIDE_HI) begin
                busy_q <= 1'b0;
                if (GUARD_EN)
                    hold_q <= '0;
            end
        end
    end

    // R3: refused write leaves storage untouched
    p_refused_write_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_req && wr_resp != RESP_OKAY) |=> $stable(store_q));

    // R5: low-word read opens the transfer and records the reader
    p_wide_open_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_ok && rd_word == WIDE_LO) |=> (busy_q && busy_prot_q == $past(rd_prot)));

    // R6: high-word read closes the transfer
    p_wide_close_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_ok && rd_word == WIDE_HI && !(wr_req && 1'b0)) |=> !busy_q);

    generate
        if (GUARD_EN) begin : g_guard_chk
            // R9: holding register wiped after completion
            p_hold_wipe_r9: assert property (@(posedge clk) disable iff (rst)
                (rd_ok && rd_word == WIDE_HI) |=> (hold_q == '0));
        end
    endgenerate

endmodule

// File: rtl/prot_axil_wr.sv
module prot_axil_wr
    import prot_regfile_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              aw_valid,
    output logic              aw_ready,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic [2:0]        aw_prot,
    input  logic              w_valid,
    output logic              w_ready,
    input  logic [DATA_W-1:0] w_data,
    input  logic [STRB_W-1:0] w_strb,
    output logic              b_valid,
    input  logic              b_ready,
    output logic [1:0]        b_resp,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output prot_t             wr_prot,
    output logic [DATA_W-1:0] wr_data,
    output logic [STRB_W-1:0] wr_strb,
    input  resp_e             wr_resp
);

    logic aw_have_q, w_have_q;

    assign aw_ready = !aw_have_q;
    assign w_ready  = !w_have_q;
    assign wr_req   = aw_have_q && w_have_q && !b_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            aw_have_q <= 1'b0;
            w_have_q  <= 1'b0;
            wr_addr   <= '0;
            wr_prot   <= '0;
            wr_data   <= '0;
            wr_strb   <= '0;
            b_valid   <= 1'b0;
            b_resp    <= 2'b00;
        end else begin
            if (aw_valid && aw_ready) begin
                aw_have_q <= 1'b1;
                wr_addr   <= aw_addr;
                wr_prot   <= prot_t'(aw_prot);
            end
            if (w_valid && w_ready) begin
                w_have_q <= 1'b1;
                wr_data  <= w_data;
                wr_strb  <= w_strb;
            end
            if (wr_req) begin
                aw_have_q <= 1'b0;
                w_have_q  <= 1'b0;
                b_valid   <= 1'b1;
                b_resp    <= wr_resp;
            end else if (b_valid && b_ready) begin
                b_valid <= 1'b0;
            end
        end
    end

    // R11: response held until taken
    p_b_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (b_valid && !b_ready) |=> (b_valid && $stable(b_resp)));

    // R11: response only after both address and data arrived
    p_b_after_both_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(b_valid) |-> $past(aw_have_q && w_have_q));

endmodule

// File: rtl/prot_axil_rd.sv
module prot_axil_rd
    import prot_regfile_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ar_valid,
    output logic              ar_ready,
    input  logic [ADDR_W-1:0] ar_addr,
    input  logic [2:0]        ar_prot,
    output logic              r_valid,
    input  logic              r_ready,
    output logic [DATA_W-1:0] r_data,
    output logic [1:0]        r_resp,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output prot_t             rd_prot,
    input  logic [DATA_W-1:0] rd_data,
    input  resp_e             rd_resp
);

    assign ar_ready = !r_valid;
    assign rd_req   = ar_valid && ar_ready;
    assign rd_addr  = ar_addr;
    assign rd_prot  = prot_t'(ar_prot);

    always_ff @(posedge clk) begin
        if (rst) begin
            r_valid <= 1'b0;
            r_data  <= '0;
            r_resp  <= 2'b00;
        end else if (rd_req) begin
            r_valid <= 1'b1;
            r_data  <= rd_data;
            r_resp  <= rd_resp;
        end else if (r_valid && r_ready) begin
            r_valid <= 1'b0;
        end
    end

    // R11: read result held until taken
    p_r_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_resp)));

    // R7: any error answer carries zero data
    p_err_blank_r7: assert property (@(posedge clk) disable iff (rst)
        (r_valid && r_resp != 2'b00) |-> (r_data == '0));

endmodule

// File: rtl/prot_regfile.sv
module prot_regfile
    import prot_regfile_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter bit GUARD_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              aw_valid,
    output logic              aw_ready,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic [2:0]        aw_prot,
    input  logic              w_valid,
    output logic              w_ready,
    input  logic [31:0]       w_data,
    input  logic [3:0]        w_strb,
    output logic              b_valid,
    input  logic              b_ready,
    output logic [1:0]        b_resp,
    input  logic              ar_valid,
    output logic              ar_ready,
    input  logic [ADDR_W-1:0] ar_addr,
    input  logic [2:0]        ar_prot,
    output logic              r_valid,
    input  logic              r_ready,
    output logic [31:0]       r_data,
    output logic [1:0]        r_resp
);

    localparam int WORD_LSB = 2;
    localparam int MAP_TOP  = WORD_LSB + WIDX_W;

    logic              wr_req, rd_req;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    prot_t             wr_prot, rd_prot;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic [STRB_W-1:0] wr_strb;
    resp_e             wr_resp, rd_resp;
    logic [WIDX_W-1:0] wr_word, rd_word;
    logic              wr_mapped, rd_mapped;

    assign wr_word   = wr_addr[WORD_LSB +: WIDX_W];
    assign rd_word   = rd_addr[WORD_LSB +: WIDX_W];
    assign wr_mapped = (wr_addr[ADDR_W-1:MAP_TOP] == '0) && (wr_addr[WORD_LSB-1:0] == '0);
    assign rd_mapped = (rd_addr[ADDR_W-1:MAP_TOP] == '0) && (rd_addr[WORD_LSB-1:0] == '0);

    prot_axil_wr #(.ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst(rst),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_prot(aw_prot),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb),
        .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_prot(wr_prot),
        .wr_data(wr_data), .wr_strb(wr_strb), .wr_resp(wr_resp)
    );

    prot_axil_rd #(.ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst(rst),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_prot(ar_prot),
        .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_resp(r_resp),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_prot(rd_prot),
        .rd_data(rd_data), .rd_resp(rd_resp)
    );

    prot_regfile_core #(.GUARD_EN(GUARD_EN)) u_core (
        .clk(clk), .rst(rst),
        .wr_req(wr_req), .wr_word(wr_word), .wr_mapped(wr_mapped), .wr_prot(wr_prot),
        .wr_data(wr_data), .wr_strb(wr_strb), .wr_resp(wr_resp),
        .rd_req(rd_req), .rd_word(rd_word), .rd_mapped(rd_mapped), .rd_prot(rd_prot),
        .rd_data(rd_data), .rd_resp(rd_resp)
    );

endmodule

// File: tb/tb_prot_regfile.sv
module tb_prot_regfile;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    localparam logic [1:0] OK  = 2'b00;
    localparam logic [1:0] SLV = 2'b10;
    localparam logic [1:0] DEC = 2'b11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        aw_valid = 0, w_valid = 0, b_ready = 0, ar_valid = 0, r_ready = 0;
    logic [7:0]  aw_addr = 0, ar_addr = 0;
    logic [2:0]  aw_prot = 0, ar_prot = 0;
    logic [31:0] w_data = 0;
    logic [3:0]  w_strb = 0;

    logic        aw_ready, w_ready, b_valid, ar_ready, r_valid;
    logic [1:0]  b_resp, r_resp;
    logic [31:0] r_data;
    logic        aw_ready2, w_ready2, b_valid2, ar_ready2, r_valid2;
    logic [1:0]  b_resp2, r_resp2;
    logic [31:0] r_data2;

    prot_regfile dut (
        .clk(clk), .rst(rst),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_prot(aw_prot),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb),
        .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_prot(ar_prot),
        .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_resp(r_resp)
    );

    prot_regfile #(.GUARD_EN(1'b0)) dut_noguard (
        .clk(clk), .rst(rst),
        .aw_valid(aw_valid), .aw_ready(aw_ready2), .aw_addr(aw_addr), .aw_prot(aw_prot),
        .w_valid(w_valid), .w_ready(w_ready2), .w_data(w_data), .w_strb(w_strb),
        .b_valid(b_valid2), .b_ready(b_ready), .b_resp(b_resp2),
        .ar_valid(ar_valid), .ar_ready(ar_ready2), .ar_addr(ar_addr), .ar_prot(ar_prot),
        .r_valid(r_valid2), .r_ready(r_ready), .r_data(r_data2), .r_resp(r_resp2)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    logic [67:0] rd_q[$];
    string       rd_tag[$];
    logic [3:0]  wr_q[$];
    string       wr_tag[$];

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: pops expected items at the falling edge before the accepting edge
    always @(negedge clk) begin
        if (!rst) begin
            if (r_valid && r_ready) begin
                if (rd_q.size() == 0) begin
                    check("R11", "unexpected read response", 32'd1, 32'd0);
                end else begin
                    logic [67:0] e;
                    string t;
                    e = rd_q.pop_front();
                    t = rd_tag.pop_front();
                    check(t, "rresp", {30'd0, r_resp}, {30'd0, e[67:66]});
                    check(t, "rdata", r_data, e[65:34]);
                    check(t, "rresp (guard off)", {30'd0, r_resp2}, {30'd0, e[33:32]});
                    check(t, "rdata (guard off)", r_data2, e[31:0]);
                end
            end
            if (b_valid && b_ready) begin
                if (wr_q.size() == 0) begin
                    check("R11", "unexpected write response", 32'd1, 32'd0);
                end else begin
                    logic [3:0] e;
                    string t;
                    e = wr_q.pop_front();
                    t = wr_tag.pop_front();
                    check(t, "bresp", {30'd0, b_resp}, {30'd0, e[3:2]});
                    check(t, "bresp (guard off)", {30'd0, b_resp2}, {30'd0, e[1:0]});
                end
            end
        end
    end

    task automatic send_aw(input logic [7:0] a, input logic [2:0] p);
        logic hs;
        aw_valid <= 1; aw_addr <= a; aw_prot <= p;
        hs = 0;
        while (!hs) begin
            hs = aw_ready;
            @(negedge clk);
        end
        aw_valid <= 0;
    endtask

    task automatic send_w(input logic [31:0] d, input logic [3:0] s);
        logic hs;
        w_valid <= 1; w_data <= d; w_strb <= s;
        hs = 0;
        while (!hs) begin
            hs = w_ready;
            @(negedge clk);
        end
        w_valid <= 0;
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [2:0] p, input logic [31:0] d,
                         input logic [3:0] s, input int order,
                         input logic [1:0] er, input logic [1:0] er2, input string tag);
        wr_q.push_back({er, er2});
        wr_tag.push_back(tag);
        if (order == 0) begin
            send_aw(a, p); send_w(d, s);
        end else if (order == 1) begin
            send_w(d, s); send_aw(a, p);
        end else begin
            logic da, dw, ha, hw;
            aw_valid <= 1; aw_addr <= a; aw_prot <= p;
            w_valid  <= 1; w_data  <= d; w_strb  <= s;
            da = 0; dw = 0;
            while (!(da && dw)) begin
                ha = aw_ready && !da;
                hw = w_ready && !dw;
                @(negedge clk);
                if (ha) begin aw_valid <= 0; da = 1; end
                if (hw) begin w_valid <= 0; dw = 1; end
            end
        end
        @(negedge clk);
        check(tag, "R11 bvalid held while bready low", {31'd0, b_valid}, 32'd1);
        @(posedge clk);
        #1 b_ready = 1;
        while (wr_q.size() != 0) @(negedge clk);
        @(posedge clk);
        #1 b_ready = 0;
        @(negedge clk);
    endtask

    task automatic do_rd(input logic [7:0] a, input logic [2:0] p,
                         input logic [1:0] er, input logic [31:0] ed,
                         input logic [1:0] er2, input logic [31:0] ed2,
                         input string tag, input int stall);
        logic hs;
        rd_q.push_back({er, ed, er2, ed2});
        rd_tag.push_back(tag);
        ar_valid <= 1; ar_addr <= a; ar_prot <= p;
        hs = 0;
        while (!hs) begin
            hs = ar_ready;
            @(negedge clk);
        end
        ar_valid <= 0;
        for (int i = 0; i < stall; i++) begin
            check(tag, "R11 rvalid held while rready low", {31'd0, r_valid}, 32'd1);
            @(negedge clk);
        end
        @(posedge clk);
        #1 r_ready = 1;
        while (rd_q.size() != 0) @(negedge clk);
        @(posedge clk);
        #1 r_ready = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R13 reset state
        check("R13", "awready", {31'd0, aw_ready}, 32'd1);
        check("R13", "wready",  {31'd0, w_ready},  32'd1);
        check("R13", "arready", {31'd0, ar_ready}, 32'd1);
        check("R13", "bvalid",  {31'd0, b_valid},  32'd0);
        check("R13", "rvalid",  {31'd0, r_valid},  32'd0);
        do_rd(8'h00, 3'b001, OK, 32'h0, OK, 32'h0, "R13 reset value", 0);
        do_rd(8'h0C, 3'b001, OK, 32'h0, OK, 32'h0, "R13 holding reset", 0);

        // R1 privileged full write and read
        do_wr(8'h00, 3'b001, 32'hAAAA5555, 4'hF, 0, OK, OK, "R1 priv write");
        do_rd(8'h00, 3'b001, OK, 32'hAAAA5555, OK, 32'hAAAA5555, "R1 priv read", 2);
        // R2 user write, data first (R11 order)
        do_wr(8'h00, 3'b000, 32'h1234BEEF, 4'hF, 1, OK, OK, "R2 R11 user write W first");
        do_rd(8'h00, 3'b001, OK, 32'hAAAABEEF, OK, 32'hAAAABEEF, "R2 refused half kept", 0);
        do_rd(8'h00, 3'b000, OK, 32'h0000BEEF, OK, 32'h0000BEEF, "R2 refused half blank", 1);
        do_wr(8'h00, 3'b000, 32'h99990000, 4'b1100, 2, OK, OK, "R2 strobes only on refused field");
        do_rd(8'h00, 3'b001, OK, 32'hAAAABEEF, OK, 32'hAAAABEEF, "R2 no change", 0);

        // R4 key word, secure data only
        do_wr(8'h04, 3'b000, 32'hCAFEF00D, 4'hF, 2, OK, OK, "R4 key write");
        do_rd(8'h04, 3'b000, OK, 32'hCAFEF00D, OK, 32'hCAFEF00D, "R4 key read", 0);
        do_wr(8'h04, 3'b010, 32'h11111111, 4'hF, 0, DEC, DEC, "R3 nonsecure write");
        do_rd(8'h04, 3'b000, OK, 32'hCAFEF00D, OK, 32'hCAFEF00D, "R3 key unchanged", 0);
        do_rd(8'h04, 3'b010, DEC, 32'h0, DEC, 32'h0, "R3 nonsecure read", 0);
        do_rd(8'h04, 3'b100, DEC, 32'h0, DEC, 32'h0, "R1 instruction read", 0);
        do_rd(8'h04, 3'b001, OK, 32'hCAFEF00D, OK, 32'hCAFEF00D, "R1 priv secure read", 0);

        // R4 unmapped and misaligned
        do_rd(8'h10, 3'b001, DEC, 32'h0, DEC, 32'h0, "R4 unmapped read", 0);
        do_wr(8'h10, 3'b001, 32'h5, 4'hF, 0, DEC, DEC, "R4 unmapped write");
        do_rd(8'h02, 3'b001, DEC, 32'h0, DEC, 32'h0, "R4 misaligned read", 0);

        // R12 byte lanes
        do_wr(8'h04, 3'b000, 32'h00000077, 4'b0001, 0, OK, OK, "R12 lane0 write");
        do_rd(8'h04, 3'b000, OK, 32'hCAFEF077, OK, 32'hCAFEF077, "R12 lane read", 0);

        // 64-bit value
        do_wr(8'h08, 3'b000, 32'h89ABCDEF, 4'hF, 0, OK, OK, "R4 wide low write");
        do_wr(8'h0C, 3'b000, 32'h01234567, 4'hF, 1, OK, OK, "R4 wide high write");
        do_rd(8'h08, 3'b001, OK, 32'h89ABCDEF, OK, 32'h89ABCDEF, "R5 open low read", 1);
        do_wr(8'h0C, 3'b001, 32'hFFFF0000, 4'hF, 0, OK, OK, "R8 same level write");
        do_rd(8'h0C, 3'b000, SLV, 32'h0, OK, 32'h01234567, "R7 R10 user interrupt", 0);
        do_wr(8'h08, 3'b010, 32'h0BADF00D, 4'hF, 2, SLV, OK, "R7 R10 nonsecure write interrupt");
        do_rd(8'h0C, 3'b011, SLV, 32'h0, OK, 32'h01234567, "R7 nonsecure read interrupt", 0);
        do_rd(8'h0C, 3'b001, OK, 32'h01234567, OK, 32'h01234567, "R6 held upper half", 2);
        do_rd(8'h0C, 3'b001, OK, 32'h0, OK, 32'h01234567, "R9 R10 holding wiped", 0);
        do_rd(8'h08, 3'b100, DEC, 32'h0, DEC, 32'h0, "R1 instruction wide read", 0);

        // R8 restart by higher privilege replaces recorded bits
        do_rd(8'h08, 3'b000, OK, 32'h89ABCDEF, OK, 32'h0BADF00D, "R8 R7 user open", 0);
        do_rd(8'h08, 3'b001, OK, 32'h89ABCDEF, OK, 32'h0BADF00D, "R8 priv reopen", 0);
        do_rd(8'h0C, 3'b000, SLV, 32'h0, OK, 32'hFFFF0000, "R8 recorded prot updated", 0);
        do_rd(8'h0C, 3'b001, OK, 32'hFFFF0000, OK, 32'hFFFF0000, "R6 complete", 0);
        do_rd(8'h08, 3'b000, OK, 32'h89ABCDEF, OK, 32'h0BADF00D, "R8 user open again", 0);
        do_rd(8'h0C, 3'b001, OK, 32'hFFFF0000, OK, 32'hFFFF0000, "R8 higher completes", 0);

        repeat (4) @(negedge clk);
        check("R11", "read items left", rd_q.size(), 32'd0);
        check("R11", "write items left", wr_q.size(), 32'd0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule